// File: doc/BRIEF.md
# Multi-Strobe Serial DAC Input Front End

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. Data arrives on one serial pin, most significant bit first, and is shifted into an input register by a shift clock built from four strobe pins of mixed polarity. Three strobes act on their rising edge and one on its falling edge. Any strobe held at its blocking level stops the others from shifting. The bit that leaves the top of the input register is presented on a serial output, so several devices can be chained on one serial line.

Two active-low load pins copy the input register into the DAC register whenever both are low together. The DAC register drives the parallel code output. An active-low clear pin and the power-on reset force both registers to a value picked by a parameter: all zeros or mid-scale (only the top bit set). Clear acts at once and is released in step with the system clock.

All pins are sampled by a free-running system clock through two-flop synchronizers. Edges are detected on the synchronized composite strobe, so the block has one clock domain. The analog ladder and the output amplifier are outside this block.

Top module: `serial_dac_frontend`

## Requirements
- R1: After power-on reset the DAC code and the input register hold the clear value (16'h0000 for the zero-scale setting, 16'h8000 for the mid-scale setting), and the serial output is 0.
- R2: A shift happens once per rising edge of the composite strobe (strobe_a | strobe_b | ~strobe_c | strobe_d). Each shift moves the input register one place towards the MSB and takes the serial input into bit 0, so a 16-bit word is received MSB first.
- R3: strobe_a_i, strobe_b_i and strobe_d_i each shift on their rising edge and strobe_c_i shifts on its falling edge, while the other strobes idle at their non-blocking levels (low, low, high, low).
- R4: While any strobe sits at its blocking level (strobe_a, strobe_b or strobe_d high, or strobe_c low), transitions on the other strobes cause no shift.
- R5: On every shift the serial output takes the MSB that leaves the input register, so it repeats the serial input delayed by 16 shifts and sends the previous word MSB first.
- R6: The DAC register copies the input register on each clock while both load_a_ni and load_b_ni are low. With only one of them low it holds its value.
- R7: Pulling clear_ni low forces the input register and the DAC register to the clear value at once, without a clock edge, and clears the serial output to 0.
- R8: Clear wins over shift and load: strobes and loads seen while clear is low, or in the two clock cycles of its synchronous release, change nothing.
- R9: When a load and a shift fall on the same clock, the DAC register takes the input register value from before that shift.
- R10: A pin change reaches the registers on the third rising system clock edge after it is set up (two synchronizer stages and one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| clear_ni | input | 1 | Active-low asynchronous clear of both registers |
| strobe_a_i | input | 1 | Shift strobe, rising edge active, blocks when high |
| strobe_b_i | input | 1 | Shift strobe, rising edge active, blocks when high |
| strobe_c_i | input | 1 | Shift strobe, falling edge active, blocks when low |
| strobe_d_i | input | 1 | Shift strobe, rising edge active, blocks when high |
| sdi_i | input | 1 | Serial data input, MSB first |
| load_a_ni | input | 1 | Active-low load enable, first of two |
| load_b_ni | input | 1 | Active-low load enable, second of two |
| sdo_o | output | 1 | Serial output for chaining the next device |
| dac_code_o | output | 16 | Parallel DAC register value |

## Verification
Words are shifted in with the shift clock coming from each strobe in turn, which tells a mix-up of polarities apart from correct edge selection. A second word shifted straight after the first shows whether the serial output carries the earlier word MSB first and not a shorter or longer delay. A strobe held at its blocking level while the others toggle, a load with only one pin low, loads held during shifting, and strobes and loads sent during clear tell apart the gating, the two-pin load condition, the pre-shift capture and the priority of clear. A behavioural model run alongside both clear-value settings is compared with the outputs on every clock, so a wrong latency also shows up.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  typedef enum logic {
    CLR_ZERO = 1'b0,
    CLR_MID  = 1'b1
  } clear_sel_e;

  localparam int unsigned STB_N = 4;
  localparam int unsigned SYNC_STAGES = 2;

  // strobe polarity: bit set = falling edge active (blocks when low)
  localparam logic [STB_N-1:0] STB_FALL_MASK = 4'b0100;

endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/dac_fe_rst_sync.sv
module dac_fe_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [dac_fe_pkg::SYNC_STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= '0;
    else          stage_q <= {stage_q[dac_fe_pkg::SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_no = stage_q[dac_fe_pkg::SYNC_STAGES-1];

endmodule

// File: rtl/dac_fe_strobe.sv
module dac_fe_strobe #(
  parameter int unsigned N = dac_fe_pkg::STB_N,
  parameter logic [N-1:0] FALL_MASK = dac_fe_pkg::STB_FALL_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stb_i,
  output logic         shift_o
);

  logic [N-1:0] norm;
  logic         comp;
  logic         comp_q;

  // normalise every strobe to "high = blocking / past its edge"
  for (genvar i = 0; i < N; i++) begin : g_pol
    if (FALL_MASK[i]) begin : g_fall
      assign norm[i] = ~stb_i[i];
    end else begin : g_rise
      assign norm[i] = stb_i[i];
    end
  end

  assign comp = |norm;

  // reset high: no spurious edge while synchronizers settle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) comp_q <= 1'b1;
    else         comp_q <= comp;
  end

  assign shift_o = comp & ~comp_q;

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |=> !shift_o);

  p_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp && $stable(comp)) |-> !shift_o);

endmodule

// File: rtl/dac_fe_regs.sv
module dac_fe_regs #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] CLR_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         regs_rst_ni,
  input  logic         shift_i,
  input  logic         sdata_i,
  input  logic         load_i,
  output logic [W-1:0] word_o,
  output logic         sdata_o
);

  logic [W-1:0] in_q;
  logic [W-1:0] dac_q;
  logic         sout_q;

  always_ff @(posedge clk_i or negedge regs_rst_ni) begin
    if (!regs_rst_ni) begin
      in_q   <= CLR_VAL;
      sout_q <= 1'b0;
    end else if (shift_i) begin
      in_q   <= {in_q[W-2:0], sdata_i};
      sout_q <= in_q[W-1];
    end
  end

  // reads in_q before any same-cycle shift lands
  always_ff @(posedge clk_i or negedge regs_rst_ni) begin
    if (!regs_rst_ni)  dac_q <= CLR_VAL;
    else if (load_i)   dac_q <= in_q;
  end

  assign word_o  = dac_q;
  assign sdata_o = sout_q;

  p_clear_value_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regs_rst_ni |-> (dac_q == CLR_VAL && in_q == CLR_VAL && !sout_q));

  p_hold_no_load_r6: assert property (@(posedge clk_i) disable iff (!regs_rst_ni)
    !load_i |=> $stable(dac_q));

  p_pre_shift_load_r9: assert property (@(posedge clk_i) disable iff (!regs_rst_ni)
    load_i |=> dac_q == $past(in_q));

  p_sdo_delay_r5: assert property (@(posedge clk_i) disable iff (!regs_rst_ni)
    shift_i |=> sout_q == $past(in_q[W-1]));

  p_no_shift_r4: assert property (@(posedge clk_i) disable iff (!regs_rst_ni)
    !shift_i |=> ($stable(in_q) && $stable(sout_q)));

endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
  parameter int unsigned WORD_W = 16,
  parameter dac_fe_pkg::clear_sel_e CLEAR_MODE = dac_fe_pkg::CLR_ZERO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_ni,
  input  logic              strobe_a_i,
  input  logic              strobe_b_i,
  input  logic              strobe_c_i,
  input  logic              strobe_d_i,
  input  logic              sdi_i,
  input  logic              load_a_ni,
  input  logic              load_b_ni,
  output logic              sdo_o,
  output logic [WORD_W-1:0] dac_code_o
);

  import dac_fe_pkg::*;

  localparam logic [WORD_W-1:0] CLR_VAL =
    (CLEAR_MODE == CLR_MID) ? {1'b1, {(WORD_W-1){1'b0}}} : '0;
  // pin bundle: {load_b, load_a, sdi, strobes[3:0]}
  localparam int unsigned PIN_N = STB_N + 3;
  localparam logic [PIN_N-1:0] PIN_RST = {2'b11, 1'b0, STB_FALL_MASK};

  logic [PIN_N-1:0] pins_raw;
  logic [PIN_N-1:0] pins_s;
  logic             shift;
  logic             load_en;
  logic             regs_rst_n;
  logic             clr_arst_n;

  assign pins_raw = {load_b_ni, load_a_ni, sdi_i,
                     strobe_d_i, strobe_c_i, strobe_b_i, strobe_a_i};

  dac_fe_sync #(.WIDTH(PIN_N), .RST_VAL(PIN_RST)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign clr_arst_n = rst_ni & clear_ni;

  dac_fe_rst_sync u_clr_sync (
    .clk_i  (clk_i),
    .arst_ni(clr_arst_n),
    .rst_no (regs_rst_n)
  );

  dac_fe_strobe #(.N(STB_N), .FALL_MASK(STB_FALL_MASK)) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (pins_s[STB_N-1:0]),
    .shift_o(shift)
  );

  assign load_en = ~pins_s[STB_N+1] & ~pins_s[STB_N+2];

  dac_fe_regs #(.W(WORD_W), .CLR_VAL(CLR_VAL)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .regs_rst_ni(regs_rst_n),
    .shift_i    (shift),
    .sdata_i    (pins_s[STB_N]),
    .load_i     (load_en),
    .word_o     (dac_code_o),
    .sdata_o    (sdo_o)
  );

  p_load_two_pins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |-> ($past(!load_a_ni, 2) && $past(!load_b_ni, 2)));

  p_clear_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_ni |-> dac_code_o == CLR_VAL);

endmodule

// File: tb/tb_serial_dac_frontend.sv
module tb_serial_dac_frontend;

  localparam logic [15:0] CLR_Z = 16'h0000;
  localparam logic [15:0] CLR_M = 16'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1;
  logic sa = 1'b0, sb = 1'b0, sc = 1'b1, sd = 1'b0;
  logic sdi = 1'b0;
  logic la_n = 1'b1, lb_n = 1'b1;
  logic sdo_z, sdo_m;
  logic [15:0] code_z, code_m;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #10 clk = ~clk;

  serial_dac_frontend #(.WORD_W(16), .CLEAR_MODE(dac_fe_pkg::CLR_ZERO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_ni(clr_n),
    .strobe_a_i(sa), .strobe_b_i(sb), .strobe_c_i(sc), .strobe_d_i(sd),
    .sdi_i(sdi), .load_a_ni(la_n), .load_b_ni(lb_n),
    .sdo_o(sdo_z), .dac_code_o(code_z));

  serial_dac_frontend #(.WORD_W(16), .CLEAR_MODE(dac_fe_pkg::CLR_MID)) dut_mid (
    .clk_i(clk), .rst_ni(rst_n), .clear_ni(clr_n),
    .strobe_a_i(sa), .strobe_b_i(sb), .strobe_c_i(sc), .strobe_d_i(sd),
    .sdi_i(sdi), .load_a_ni(la_n), .load_b_ni(lb_n),
    .sdo_o(sdo_m), .dac_code_o(code_m));

  // ---------------- behavioural reference model ----------------
  // pin order: a b c d sdi la lb
  bit p1 [7];
  bit p2 [7];
  bit comp_prev;
  bit rs1, rs2;
  int m_in  [2];
  int m_dac [2];
  bit m_so  [2];
  int clr_v [2] = '{0, 32768};

  task automatic model_reset_pins();
    p1 = '{0, 0, 1, 0, 0, 1, 1};
    p2 = '{0, 0, 1, 0, 0, 1, 1};
    comp_prev = 1;
  endtask

  always @(posedge clk) begin
    bit edge_s, ld, d, ok, regs_rst;
    edge_s = 0; ld = 0; d = 0;
    if (!rst_n) begin
      model_reset_pins();
    end else begin
      bit comp;
      comp   = p2[0] || p2[1] || !p2[2] || p2[3];
      edge_s = comp && !comp_prev;
      ld     = !p2[5] && !p2[6];
      d      = p2[4];
      comp_prev = comp;
      p2 = p1;
      p1 = '{sa, sb, sc, sd, sdi, la_n, lb_n};
    end
    ok = rst_n && clr_n;
    regs_rst = !ok || !rs2;
    rs2 = ok ? rs1 : 1'b0;
    rs1 = ok;
    for (int v = 0; v < 2; v++) begin
      if (regs_rst) begin
        m_in[v] = clr_v[v]; m_dac[v] = clr_v[v]; m_so[v] = 0;
      end else begin
        if (ld) m_dac[v] = m_in[v];
        if (edge_s) begin
          m_so[v] = (m_in[v] >> 15) & 1;
          m_in[v] = ((m_in[v] << 1) | int'(d)) & 16'hFFFF;
        end
      end
    end
  end

  // every-clock comparison against the model (R10 cycle accuracy)
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      checks += 4;
      if (code_z !== 16'(m_dac[0])) begin
        errors++; $display("FAIL R10 zero dac act=%h exp=%h t=%0t", code_z, 16'(m_dac[0]), $time);
      end
      if (code_m !== 16'(m_dac[1])) begin
        errors++; $display("FAIL R10 mid dac act=%h exp=%h t=%0t", code_m, 16'(m_dac[1]), $time);
      end
      if (sdo_z !== m_so[0]) begin
        errors++; $display("FAIL R10 zero sdo act=%b exp=%b t=%0t", sdo_z, m_so[0], $time);
      end
      if (sdo_m !== m_so[1]) begin
        errors++; $display("FAIL R10 mid sdo act=%b exp=%b t=%0t", sdo_m, m_so[1], $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // sel: 0=a 1=b 2=c 3=d
  task automatic strobe_set(int sel, bit active);
    case (sel)
      0: sa = active;
      1: sb = active;
      2: sc = !active;
      default: sd = active;
    endcase
  endtask

  task automatic send_bit(bit b, int sel);
    sdi = b;
    wait_n(1);
    strobe_set(sel, 1);
    wait_n(3);
    strobe_set(sel, 0);
    wait_n(3);
  endtask

  // sends word; checks sdo against prev word bit by bit when chk_prev set
  task automatic send_word(logic [15:0] w, int sel, bit chk_prev, logic [15:0] prev);
    for (int i = 15; i >= 0; i--) begin
      send_bit(w[i], sel);
      if (chk_prev) begin
        chk("R5 sdo zero", {15'd0, sdo_z}, {15'd0, prev[i]});
        chk("R5 sdo mid",  {15'd0, sdo_m}, {15'd0, prev[i]});
      end
    end
  endtask

  task automatic do_load();
    la_n = 0; lb_n = 0;
    wait_n(4);
    la_n = 1; lb_n = 1;
    wait_n(4);
  endtask

  task automatic chk_both(string tag, logic [15:0] ez, logic [15:0] em);
    chk({tag, " zero"}, code_z, ez);
    chk({tag, " mid"},  code_m, em);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    wait_n(4);
    #1;
    chk_both("R1 reset dac", CLR_Z, CLR_M);
    chk("R1 reset sdo", {14'd0, sdo_z, sdo_m}, 16'd0);
    rst_n = 1;
    cmp_en = 1;
    wait_n(4);

    // R2/R3: word via strobe a, then load
    send_word(16'hA5C3, 0, 0, 16'h0);
    chk_both("R6 no load yet", CLR_Z, CLR_M);
    do_load();
    chk_both("R2 word a", 16'hA5C3, 16'hA5C3);

    // R3/R5: next word via strobe c (falling), sdo carries previous word
    send_word(16'h3C0F, 2, 1, 16'hA5C3);
    do_load();
    chk_both("R3 word c", 16'h3C0F, 16'h3C0F);

    send_word(16'h5A96, 1, 1, 16'h3C0F);
    do_load();
    chk_both("R3 word b", 16'h5A96, 16'h5A96);

    send_word(16'hF00D, 3, 1, 16'h5A96);
    do_load();
    chk_both("R3 word d", 16'hF00D, 16'hF00D);

    // R4: b held high (its rise shifts once), other strobes toggled
    sdi = 1;
    wait_n(1);
    sb = 1;
    wait_n(3);
    for (int k = 0; k < 3; k++) begin
      sdi = k[0];
      sa = 1; wait_n(3); sa = 0; wait_n(3);
      sc = 0; wait_n(3); sc = 1; wait_n(3);
      sd = 1; wait_n(3); sd = 0; wait_n(3);
    end
    sb = 0;
    wait_n(3);
    do_load();
    chk_both("R4 blocked", 16'hE01B, 16'hE01B);

    // R6: one load pin alone has no effect
    send_word(16'h1234, 0, 0, 16'h0);
    la_n = 0; wait_n(6); la_n = 1; wait_n(4);
    chk_both("R6 only a", 16'hE01B, 16'hE01B);
    lb_n = 0; wait_n(6); lb_n = 1; wait_n(4);
    chk_both("R6 only b", 16'hE01B, 16'hE01B);
    do_load();
    chk_both("R6 both", 16'h1234, 16'h1234);

    // R9: load held while shifting; dac follows, ends at new word
    la_n = 0; lb_n = 0;
    send_word(16'hBEEF, 2, 0, 16'h0);
    wait_n(2);
    chk_both("R9 load during shift", 16'hBEEF, 16'hBEEF);
    la_n = 1; lb_n = 1;
    wait_n(4);

    // R7: clear acts before any clock edge
    @(negedge clk);
    #2 clr_n = 0;
    #1;
    chk_both("R7 async clear", CLR_Z, CLR_M);
    chk("R7 sdo cleared", {14'd0, sdo_z, sdo_m}, 16'd0);

    // R8: strobes and loads during clear are ignored
    la_n = 0; lb_n = 0;
    send_word(16'h7777, 0, 0, 16'h0);
    chk_both("R8 clear holds", CLR_Z, CLR_M);
    la_n = 1; lb_n = 1;
    wait_n(2);
    clr_n = 1;
    wait_n(5);
    do_load();
    chk_both("R8 input cleared", CLR_Z, CLR_M);

    // R5: bits after clear carry out clear-value MSB first (same in both via model)
    send_word(16'h0F0F, 3, 0, 16'h0);
    do_load();
    chk_both("R2 after clear", 16'h0F0F, 16'h0F0F);

    wait_n(4);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule